// File: doc/BRIEF.md
# Linked-Pair Output Compare Timer

This block is a free-running up-counter with two output-compare channels. The counter climbs from zero to a programmable modulo value and then returns to zero. That return cycle is the overflow event. It sets an overflow flag, and the flag can raise an interrupt. Each channel holds a compare value. When the counter equals that value, the channel toggles its output pin, sets its flag and, if enabled, raises its interrupt.

Each channel can run on its own in unbuffered mode. In that mode a new compare value replaces the active one immediately. A value written after the counter has already passed it is therefore missed for the rest of that period. The two channels can also be linked. In linked mode the two compare registers take turns controlling the channel 0 pin. Channel 0 controls first. Writing the idle register of the pair hands control to it at the next overflow, so software can prepare the next compare value without touching the live one. While linked, channel 1 stops driving its own pin and signals this by dropping its output-enable.

Registers are reached through a byte-wide write/read port. A 16-bit value is written high byte first. Comparing on that register pauses until its low byte arrives.

Top module: `occ_timer`

## Requirements
- R1: After reset the counter is 0 and the modulo value is 0xFFFF. Each cycle the counter increments by one. In the cycle where it equals the modulo value it returns to 0 instead. Counter bytes read at addresses 3 (high) and 4 (low); modulo bytes are at 1 (high) and 2 (low).
- R2: The cycle in which the counter returns to 0 sets the overflow flag (bit 7 of address 0). `irq_ovf` is the overflow flag ANDed with the overflow enable (bit 0 of address 0).
- R3: In unbuffered mode, a compare-register write takes effect from the next cycle. When the counter equals the compare value, the channel's pin toggles and its flag sets, both one cycle later.
- R4: A compare value written after the counter has already passed it produces no compare and no toggle until the counter reaches it in the following period.
- R5: Writing a compare high byte (channel 0 at address 6, channel 1 at address 9) suppresses that channel's compares until its low byte (address 7, respectively 10) is written.
- R6: A flag (bit 7 of address 0, 5 or 8) clears only when a read of its address sees the flag set and is then followed by a write of that address with bit 7 at 0. A write without the prior read leaves the flag set.
- R7: `irq_ch0` and `irq_ch1` equal each channel's flag ANDed with its enable (bit 0 of address 5, respectively 8).
- R8: Bit 4 of address 5 links the pair. Once linked, channel 0's compare value first controls `tch0`, and compares of either register toggle only `tch0`.
- R9: While linked, a low-byte write to the register not in control makes that register the controller from the counter value 0 after the next overflow. Only the controlling register produces compares and sets its flag.
- R10: While linked, `tch1_oe` is 0 and `tch1` holds its level. When unlinked, `tch1_oe` is 1.
- R11: Reset clears the counter, all flags, the link bit, both pins and all interrupt requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; arms flag clearing |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tch0 | output | 1 | Channel 0 compare pin (linked output) |
| tch1 | output | 1 | Channel 1 compare pin |
| tch1_oe | output | 1 | High while channel 1 drives its pin |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_ch0 | output | 1 | Channel 0 compare interrupt request |
| irq_ch1 | output | 1 | Channel 1 compare interrupt request |

## Verification
The hardest case to reach is timing-critical: a write must land after the counter has passed the new value but before it reaches the old one, or a hand-off must be requested in the middle of a period. The stimulus sets a short modulo period. It then waits on the bench's own model of the counter until a chosen count and places each write at a known point in the period. It then watches a full period with the old controller and the next period with the new one. A behavioural model runs alongside and is compared with every pin, interrupt and read value on each clock.

// File: rtl/occ_pkg.sv
package occ_pkg;
   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
   localparam logic [ADDR_W-1:0] A_MOD_H = 4'd1;
   localparam logic [ADDR_W-1:0] A_MOD_L = 4'd2;
   localparam logic [ADDR_W-1:0] A_CNT_H = 4'd3;
   localparam logic [ADDR_W-1:0] A_CNT_L = 4'd4;
   // per channel: control at base, compare high at base+1, low at base+2
   localparam logic [ADDR_W-1:0] A_SC0   = 4'd5;
   localparam logic [ADDR_W-1:0] A_SC1   = 4'd8;

   localparam int B_FLAG = 7;
   localparam int B_LINK = 4;
   localparam int B_IE   = 0;

   typedef struct packed {
      logic wr_hi;
      logic wr_lo;
      logic sc_wr;
      logic sc_rd;
   } chan_acc_t;
endpackage

// File: rtl/occ_flag.sv
module occ_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic rd,
   input  logic wr,
   input  logic wbit,
   output logic flag
);
   logic arm_q;
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (set)
            flag_q <= 1'b1;
         else if (wr && arm_q && !wbit)
            flag_q <= 1'b0;
         if (wr)
            arm_q <= 1'b0;
         else if (rd && flag_q)
            arm_q <= 1'b1;
      end
   end

   assign flag = flag_q;

   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n) set |=> flag);
   p_keep_unarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !arm_q) |=> flag);
endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
   parameter int             CNT_W   = 16,
   parameter logic [CNT_W-1:0] MOD_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_wr_hi,
   input  logic             mod_wr_lo,
   input  logic [7:0]       wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] mod,
   output logic             wrap
);
   localparam int HI_W = CNT_W - 8;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mod_q;

   assign wrap = (cnt_q == mod_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mod_q <= MOD_RST;
      end else begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         if (mod_wr_hi) mod_q[CNT_W-1:8] <= wdata[HI_W-1:0];
         if (mod_wr_lo) mod_q[7:0]       <= wdata;
      end
   end

   assign cnt = cnt_q;
   assign mod = mod_q;

   p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));
   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/occ_cmp_chan.sv
module occ_cmp_chan
   import occ_pkg::*;
#(
   parameter int CNT_W         = 16,
   parameter bit INHIBIT_ON_HI = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             en,
   input  chan_acc_t        acc,
   input  logic [7:0]       wdata,
   output logic [CNT_W-1:0] cmp,
   output logic             hit,
   output logic             lo_done,
   output logic             flag,
   output logic             ie
);
   localparam int HI_W = CNT_W - 8;

   logic [CNT_W-1:0] cmp_q;
   logic             ie_q;
   logic             inh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '1;
         ie_q  <= 1'b0;
      end else begin
         if (acc.wr_hi) cmp_q[CNT_W-1:8] <= wdata[HI_W-1:0];
         if (acc.wr_lo) cmp_q[7:0]       <= wdata;
         if (acc.sc_wr) ie_q             <= wdata[B_IE];
      end
   end

   generate
      if (INHIBIT_ON_HI) begin : g_inh
         logic inh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          inh_q <= 1'b0;
            else if (acc.wr_lo)  inh_q <= 1'b0;
            else if (acc.wr_hi)  inh_q <= 1'b1;
         end
         assign inh = inh_q;

         p_hi_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            acc.wr_hi |=> !hit);
      end else begin : g_no_inh
         assign inh = 1'b0;
      end
   endgenerate

   assign hit     = en && !inh && (cnt == cmp_q);
   assign lo_done = acc.wr_lo;
   assign cmp     = cmp_q;
   assign ie      = ie_q;

   occ_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (hit),
      .rd   (acc.sc_rd),
      .wr   (acc.sc_wr),
      .wbit (wdata[B_FLAG]),
      .flag (flag)
   );
endmodule

// File: rtl/occ_link_ctl.sv
module occ_link_ctl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       link,
   input  logic       wrap,
   input  logic [1:0] lo_done,
   output logic       active
);
   logic act_q, pend_q;
   logic act_n, pend_n;

   always_comb begin
      act_n  = act_q;
      pend_n = pend_q;
      if (wrap && pend_q) begin
         act_n  = ~act_q;
         pend_n = 1'b0;
      end
      if (act_q ? lo_done[0] : lo_done[1])
         pend_n = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (!link) begin
         act_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         act_q  <= act_n;
         pend_q <= pend_n;
      end
   end

   assign active = act_q;

   p_first_ch0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !link |=> !active);
   p_swap_on_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (link && !wrap) |=> $stable(active));
endmodule

// File: rtl/occ_timer.sv
module occ_timer
   import occ_pkg::*;
#(
   parameter int               CNT_W         = 16,
   parameter logic [CNT_W-1:0] MOD_RST       = '1,
   parameter bit               INHIBIT_ON_HI = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              tch0,
   output logic              tch1,
   output logic              tch1_oe,
   output logic              irq_ovf,
   output logic              irq_ch0,
   output logic              irq_ch1
);
   localparam int NCH  = 2;
   localparam int HI_W = CNT_W - 8;

   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
         $error("occ_timer: CNT_W must lie in 9..16");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, mod;
   logic             wrap;
   logic             link_q, ovf_ie_q, ovf_flag, active;
   logic             tch0_q, tch1_q;
   chan_acc_t        acc [NCH];
   logic [CNT_W-1:0] cmp [NCH];
   logic [NCH-1:0]   hit, lo_done, flag, ie, en;

   occ_counter #(.CNT_W(CNT_W), .MOD_RST(MOD_RST)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .mod_wr_hi(wr_en && addr == A_MOD_H),
      .mod_wr_lo(wr_en && addr == A_MOD_L),
      .wdata    (wdata),
      .cnt      (cnt),
      .mod      (mod),
      .wrap     (wrap)
   );

   generate
      for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
         localparam logic [ADDR_W-1:0] SC  = (gi == 0) ? A_SC0 : A_SC1;
         localparam logic [ADDR_W-1:0] CHI = SC + 4'd1;
         localparam logic [ADDR_W-1:0] CLO = SC + 4'd2;
         localparam logic              IDX = 1'(gi);

         assign acc[gi] = '{wr_hi: wr_en && addr == CHI,
                            wr_lo: wr_en && addr == CLO,
                            sc_wr: wr_en && addr == SC,
                            sc_rd: rd_en && addr == SC};
         assign en[gi]  = link_q ? (active == IDX) : 1'b1;

         occ_cmp_chan #(.CNT_W(CNT_W), .INHIBIT_ON_HI(INHIBIT_ON_HI)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt    (cnt),
            .en     (en[gi]),
            .acc    (acc[gi]),
            .wdata  (wdata),
            .cmp    (cmp[gi]),
            .hit    (hit[gi]),
            .lo_done(lo_done[gi]),
            .flag   (flag[gi]),
            .ie     (ie[gi])
         );
      end
   endgenerate

   occ_link_ctl u_link (
      .clk    (clk),
      .rst_n  (rst_n),
      .link   (link_q),
      .wrap   (wrap),
      .lo_done(lo_done),
      .active (active)
   );

   occ_flag u_ovf (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (wrap),
      .rd   (rd_en && addr == A_CTRL),
      .wr   (wr_en && addr == A_CTRL),
      .wbit (wdata[B_FLAG]),
      .flag (ovf_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q   <= 1'b0;
         ovf_ie_q <= 1'b0;
         tch0_q   <= 1'b0;
         tch1_q   <= 1'b0;
      end else begin
         if (wr_en && addr == A_SC0)  link_q   <= wdata[B_LINK];
         if (wr_en && addr == A_CTRL) ovf_ie_q <= wdata[B_IE];
         tch0_q <= tch0_q ^ (hit[0] | (link_q & hit[1]));
         tch1_q <= tch1_q ^ (!link_q & hit[1]);
      end
   end

   function automatic logic [7:0] hi_byte(input logic [CNT_W-1:0] v);
      logic [7:0] b;
      b = '0;
      b[HI_W-1:0] = v[CNT_W-1:8];
      return b;
   endfunction

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL:  begin rdata[B_FLAG] = ovf_flag; rdata[B_IE] = ovf_ie_q; end
         A_MOD_H: rdata = hi_byte(mod);
         A_MOD_L: rdata = mod[7:0];
         A_CNT_H: rdata = hi_byte(cnt);
         A_CNT_L: rdata = cnt[7:0];
         A_SC0:   begin rdata[B_FLAG] = flag[0]; rdata[B_LINK] = link_q; rdata[B_IE] = ie[0]; end
         4'd6:    rdata = hi_byte(cmp[0]);
         4'd7:    rdata = cmp[0][7:0];
         A_SC1:   begin rdata[B_FLAG] = flag[1]; rdata[B_IE] = ie[1]; end
         4'd9:    rdata = hi_byte(cmp[1]);
         4'd10:   rdata = cmp[1][7:0];
         default: rdata = '0;
      endcase
   end

   assign tch0    = tch0_q;
   assign tch1    = tch1_q;
   assign tch1_oe = !link_q;
   assign irq_ovf = ovf_flag && ovf_ie_q;
   assign irq_ch0 = flag[0] && ie[0];
   assign irq_ch1 = flag[1] && ie[1];

   p_pin1_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      link_q |=> $stable(tch1));
   p_ovf_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ovf_flag);
endmodule

// File: tb/sim_occ_timer.sv
module sim_occ_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       tch0, tch1, tch1_oe, irq_ovf, irq_ch0, irq_ch1;

   occ_timer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tch0(tch0), .tch1(tch1), .tch1_oe(tch1_oe),
      .irq_ovf(irq_ovf), .irq_ch0(irq_ch0), .irq_ch1(irq_ch1)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   // behavioural reference state
   int m_cnt, m_mod;
   int m_cmp[2];
   bit m_inh[2], m_flag[2], m_arm[2], m_ie[2];
   bit m_ovf, m_ovf_arm, m_ovf_ie, m_link, m_act, m_pend, m_out0, m_out1;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic void model_reset();
      m_cnt = 0; m_mod = 16'hFFFF;
      for (int i = 0; i < 2; i++) begin
         m_cmp[i] = 16'hFFFF; m_inh[i] = 0; m_flag[i] = 0; m_arm[i] = 0; m_ie[i] = 0;
      end
      m_ovf = 0; m_ovf_arm = 0; m_ovf_ie = 0; m_link = 0; m_act = 0; m_pend = 0;
      m_out0 = 0; m_out1 = 0;
   endfunction

   function automatic bit [1:0] next_flag(bit f, bit arm, bit set, bit rd, bit wr, bit wb);
      bit nf, na;
      nf = set ? 1'b1 : ((wr && arm && !wb) ? 1'b0 : f);
      na = wr ? 1'b0 : ((rd && f) ? 1'b1 : arm);
      return {nf, na};
   endfunction

   function automatic int mread(int a);
      case (a)
         0:  return (int'(m_ovf) << 7) | int'(m_ovf_ie);
         1:  return m_mod >> 8;
         2:  return m_mod & 255;
         3:  return m_cnt >> 8;
         4:  return m_cnt & 255;
         5:  return (int'(m_flag[0]) << 7) | (int'(m_link) << 4) | int'(m_ie[0]);
         6:  return m_cmp[0] >> 8;
         7:  return m_cmp[0] & 255;
         8:  return (int'(m_flag[1]) << 7) | int'(m_ie[1]);
         9:  return m_cmp[1] >> 8;
         10: return m_cmp[1] & 255;
         default: return 0;
      endcase
   endfunction

   function automatic void model_step();
      bit hit[2];
      bit ovfe, w, r, wb;
      bit [1:0] fa;
      int a, d, sc;
      w = wr_en; r = rd_en; a = int'(addr); d = int'(wdata); wb = wdata[7];
      ovfe = (m_cnt == m_mod);
      for (int i = 0; i < 2; i++)
         hit[i] = (m_link ? (int'(m_act) == i) : 1'b1) && !m_inh[i] && (m_cnt == m_cmp[i]);
      // hand-off bookkeeping uses the link setting held before this edge
      if (!m_link) begin
         m_act = 0; m_pend = 0;
      end else begin
         bit na, np;
         na = m_act; np = m_pend;
         if (ovfe && m_pend) begin na = !m_act; np = 0; end
         if (w && a == (m_act ? 7 : 10)) np = 1;
         m_act = na; m_pend = np;
      end
      m_out0 ^= hit[0] | (m_link & hit[1]);
      m_out1 ^= !m_link & hit[1];
      fa = next_flag(m_ovf, m_ovf_arm, ovfe, r && a == 0, w && a == 0, wb);
      m_ovf = fa[1]; m_ovf_arm = fa[0];
      for (int i = 0; i < 2; i++) begin
         sc = (i == 0) ? 5 : 8;
         fa = next_flag(m_flag[i], m_arm[i], hit[i], r && a == sc, w && a == sc, wb);
         m_flag[i] = fa[1]; m_arm[i] = fa[0];
      end
      if (w) begin
         case (a)
            0:  m_ovf_ie = bit'(d & 1);
            1:  m_mod = (m_mod & 255) | (d << 8);
            2:  m_mod = (m_mod & 16'hFF00) | d;
            5:  begin m_ie[0] = bit'(d & 1); m_link = bit'((d >> 4) & 1); end
            6:  begin m_cmp[0] = (m_cmp[0] & 255) | (d << 8); m_inh[0] = 1; end
            7:  begin m_cmp[0] = (m_cmp[0] & 16'hFF00) | d; m_inh[0] = 0; end
            8:  m_ie[1] = bit'(d & 1);
            9:  begin m_cmp[1] = (m_cmp[1] & 255) | (d << 8); m_inh[1] = 1; end
            10: begin m_cmp[1] = (m_cmp[1] & 16'hFF00) | d; m_inh[1] = 0; end
            default: ;
         endcase
      end
      m_cnt = ovfe ? 0 : ((m_cnt + 1) & 16'hFFFF);
   endfunction

   function automatic string req_of(int a);
      case (a)
         0:       return "R2";
         1, 2, 3, 4: return "R1";
         5, 8:    return "R6";
         default: return "R3";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else        model_step();
   end

   // compare with the reference on every clock, away from the edge
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("R3",  "tch0",    int'(tch0),    int'(m_out0));
         chk("R10", "tch1",    int'(tch1),    int'(m_out1));
         chk("R10", "tch1_oe", int'(tch1_oe), int'(!m_link));
         chk("R2",  "irq_ovf", int'(irq_ovf), int'(m_ovf & m_ovf_ie));
         chk("R7",  "irq_ch0", int'(irq_ch0), int'(m_flag[0] & m_ie[0]));
         chk("R7",  "irq_ch1", int'(irq_ch1), int'(m_flag[1] & m_ie[1]));
         if (rd_en) chk(req_of(int'(addr)), "rdata", int'(rdata), mread(int'(addr)));
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog R1 actual=%0d expected=150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic bus_wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(int a, output int v);
      @(negedge clk);
      rd_en = 1'b1; addr = 4'(a);
      #2 v = int'(rdata);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_cnt(int v);
      do @(negedge clk); while (m_cnt != v);
   endtask

   initial begin
      int v, t0, t1, p0;
      model_reset();
      repeat (3) @(negedge clk);
      // R11: reset state at the pins
      chk("R11", "tch0 in reset", int'(tch0), 0);
      chk("R11", "tch1 in reset", int'(tch1), 0);
      chk("R11", "tch1_oe in reset", int'(tch1_oe), 1);
      chk("R11", "irq_ovf in reset", int'(irq_ovf), 0);
      rst_n = 1'b1;

      bus_wr(1, 0); bus_wr(2, 99);
      bus_wr(0, 8'h01);

      // R1: wrap back to zero
      wait_cnt(99);
      bus_rd(4, v);
      chk("R1", "count just after wrap", v, 0);
      // R2: overflow flag raised
      chk("R2", "irq_ovf after wrap", int'(irq_ovf), 1);

      // R6: write without prior read leaves flag
      bus_wr(0, 8'h01);
      bus_rd(0, v);
      chk("R6", "ovf flag after unarmed write", (v >> 7) & 1, 1);
      bus_wr(0, 8'h01);
      bus_rd(0, v);
      chk("R6", "ovf flag after read then write", (v >> 7) & 1, 0);

      // R3 / R7: unbuffered compare at 50
      bus_wr(6, 0); bus_wr(7, 50); bus_wr(5, 8'h01);
      while (!irq_ch0) @(negedge clk);
      chk("R3", "tch0 toggled at compare", int'(tch0), 1);
      chk("R7", "irq_ch0 with enable", int'(irq_ch0), 1);
      bus_rd(5, v); bus_wr(5, 8'h01);

      // R4: missed compare
      bus_wr(7, 80);
      wait_cnt(85);
      bus_rd(5, v); bus_wr(5, 8'h01);
      wait_cnt(40);
      bus_wr(7, 30);
      p0 = int'(tch0);
      wait_cnt(99);
      bus_rd(5, v);
      chk("R4", "no compare after passed value", (v >> 7) & 1, 0);
      chk("R4", "tch0 unchanged in missed period", int'(tch0), p0);
      wait_cnt(35);
      bus_rd(5, v);
      chk("R4", "compare in next period", (v >> 7) & 1, 1);
      bus_wr(5, 8'h01);

      // R5: high byte write inhibits until low byte
      wait_cnt(5);
      p0 = int'(tch0);
      bus_wr(6, 0);
      wait_cnt(99);
      wait_cnt(50);
      chk("R5", "tch0 held while inhibited", int'(tch0), p0);
      bus_rd(5, v);
      chk("R5", "no flag while inhibited", (v >> 7) & 1, 0);
      bus_wr(7, 30);
      wait_cnt(35);
      bus_rd(5, v);
      chk("R5", "compare after low byte", (v >> 7) & 1, 1);
      bus_wr(5, 8'h01);

      // channel 1 unlinked, then link
      bus_wr(9, 0); bus_wr(10, 70); bus_wr(8, 8'h01);
      wait_cnt(75);
      bus_rd(8, v); bus_wr(8, 8'h01);
      bus_wr(7, 20);
      wait_cnt(90);
      bus_wr(5, 8'h11);
      bus_rd(5, v); bus_wr(5, 8'h11);
      chk("R10", "tch1_oe low when linked", int'(tch1_oe), 0);
      t1 = int'(tch1);

      // period A: channel 0 controls
      wait_cnt(25);
      bus_rd(5, v);
      chk("R8", "channel 0 controls first", (v >> 7) & 1, 1);
      bus_wr(5, 8'h11);
      wait_cnt(40);
      bus_wr(10, 70);
      wait_cnt(75);
      bus_rd(8, v);
      chk("R9", "hand-off waits for overflow", (v >> 7) & 1, 0);
      t0 = int'(tch0);

      // period B: channel 1 controls
      wait_cnt(25);
      chk("R9", "old register silent after hand-off", int'(tch0), t0);
      bus_rd(5, v);
      chk("R9", "channel 0 flag stays clear", (v >> 7) & 1, 0);
      wait_cnt(75);
      chk("R8", "channel 1 compare toggles tch0", int'(tch0), 1 - t0);
      bus_rd(8, v);
      chk("R9", "channel 1 flag after hand-off", (v >> 7) & 1, 1);
      chk("R10", "tch1 held while linked", int'(tch1), t1);
      bus_wr(8, 8'h01);

      // hand back to channel 0
      bus_wr(7, 20);
      wait_cnt(25);
      bus_rd(5, v);
      chk("R9", "control returns to channel 0", (v >> 7) & 1, 1);

      bus_wr(5, 8'h01);
      @(negedge clk);
      chk("R10", "tch1_oe high after unlink", int'(tch1_oe), 1);

      // R11: reset mid-run
      bus_wr(5, 8'h11);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11", "tch0 after reset", int'(tch0), 0);
      chk("R11", "tch1_oe after reset", int'(tch1_oe), 1);
      chk("R11", "irq_ch0 after reset", int'(irq_ch0), 0);
      rst_n = 1'b1;
      bus_rd(5, v);
      chk("R11", "link and flag cleared", v, 0);
      bus_rd(0, v);
      chk("R11", "overflow flag cleared", v, 0);
      bus_rd(3, v);
      chk("R11", "counter high byte cleared", v, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule